// File: doc/BRIEF.md
# SDRAM Bank State Timing Tracker

This block observes a decoded DDR2-style command stream, one command per clock, and keeps a model of what every bank is doing. Each bank is either idle, opening a row, holding an open row, or in one of several timed transient states: closing a row, finishing an auto-closing read or write, refreshing, or loading the mode register. Every transient state lasts a cycle count that is captured from configuration inputs while reset is held.

A command that is not legal for the current state raises a one-cycle violation pulse. That command is then discarded for state tracking. The block reports the per-bank state as a packed vector and a device-wide flag that is high when every bank is idle. Data bursts are modelled only as a busy window whose length is a configured number of cycles. The tracker serves as a protocol monitor beside a memory controller or a memory model.

Top module: `sdram_bank_tracker`

## Requirements
- R1: An ACTIVATE (cs_n,ras_n,cas_n,we_n = 0011) to an idle bank puts that bank in state 1 (opening) for tRCD cycles. The bank then enters state 2 (open).
- R2: A PRECHARGE with a10=0 (0010) to an idle or open bank puts that bank in state 3 (closing) for tRP cycles. The bank then returns to state 0 (idle).
- R3: A PRECHARGE with a10=1 is legal only when every bank is idle or open. It puts all banks in state 3 for tRP cycles, after which all banks are idle.
- R4: A REFRESH (0001) is legal only when all banks are idle and no burst is running. It puts all banks in state 6 for tRFC cycles, after which all banks are idle.
- R5: A LOAD MODE (0000) has the same precondition as REFRESH. It puts all banks in state 7 for tMRD cycles, after which all banks are idle.
- R6: A READ (0101) or WRITE (0100) with a10=1 to an open bank puts that bank in state 4 (read) or state 5 (write). The bank stays there for burst length plus tRP cycles and then returns to idle.
- R7: A READ or WRITE with a10=0 to an open bank leaves the bank open and starts a burst window of burst-length cycles. A WRITE issued while a read burst window is still running is a violation.
- R8: While a bank is in any of the states 1, 3, 4, 5, 6 or 7, any command addressed to that bank or to all banks, other than NOP (0111) or DESELECT (cs_n=1), is a violation and does not change any state.
- R9: The code 0110 is reserved and is always a violation. NOP and DESELECT are never violations. `violation` is registered and is high exactly in the cycle after the offending command. An offending command changes no bank state.
- R10: The timing values are captured only while rst_n is low, and a captured value of 0 is treated as 1. Changing the configuration inputs after reset has no effect.
- R11: After reset every bank is in state 0, `violation` is low and `all_idle` is high. `all_idle` is high exactly when every bank is in state 0.
- R12: An ACTIVATE to a bank that is not idle is a violation. So is a READ or WRITE to a bank that is not open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | BA_W | Target bank of the command |
| a10 | input | 1 | All-banks select for PRECHARGE; auto-close select for READ/WRITE |
| cfg_trcd | input | CW | Row open time in cycles |
| cfg_trp | input | CW | Row close time in cycles |
| cfg_trfc | input | CW | Refresh time in cycles |
| cfg_tmrd | input | CW | Mode load time in cycles |
| cfg_burst | input | CW | Burst window length in cycles |
| bank_state | output | 3*NUM_BANKS | State code of bank i in bits [3i+2:3i] |
| all_idle | output | 1 | All banks in state 0 |
| violation | output | 1 | Illegal command seen in the previous cycle |

## Verification
A table-driven sequence opens, reads, writes and closes rows on different banks. Within it, commands that a correct tracker must reject are interleaved with legal ones. This separates a design that times each transient state to the exact cycle from one that is off by one. It also separates a design that guards each command against the right bank state from one that checks only the target bank or ignores the burst window. Refresh and mode load are tried both with a busy bank and with all banks idle, which exercises the device-wide precondition. A second reset with minimum timing values checks the one-cycle case and a close issued to an already idle bank.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [3:0] {
        K_NOP, K_DESEL, K_ACT, K_RD, K_WR, K_PRE, K_REF, K_MRS, K_RSV
    } cmd_kind_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_OPENING = 3'd1,
        BK_OPEN    = 3'd2,
        BK_CLOSING = 3'd3,
        BK_RD_AUTO = 3'd4,
        BK_WR_AUTO = 3'd5,
        BK_REFRESH = 3'd6,
        BK_MODE    = 3'd7
    } bank_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_ACT, OP_PRE, OP_RDAP, OP_WRAP, OP_REF, OP_MRS
    } bank_op_e;

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
    import sbt_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output cmd_kind_e kind
);
    always_comb begin
        if (cs_n) begin
            kind = K_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  kind = K_NOP;
                3'b011:  kind = K_ACT;
                3'b101:  kind = K_RD;
                3'b100:  kind = K_WR;
                3'b010:  kind = K_PRE;
                3'b001:  kind = K_REF;
                3'b000:  kind = K_MRS;
                default: kind = K_RSV;
            endcase
        end
    end
endmodule

// File: rtl/sbt_burst_timer.sv
module sbt_burst_timer
    import sbt_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_rd,
    input  logic [CW-1:0] t_burst,
    output logic          busy,
    output logic          rd_busy
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rd;
    } bt_t;

    bt_t bt_d, bt_q;

    always_comb begin
        bt_d = bt_q;
        if (bt_q.cnt != '0) begin
            bt_d.cnt = bt_q.cnt - CW'(1);
            if (bt_q.cnt == CW'(1)) bt_d.rd = 1'b0;
        end
        if (start) begin
            bt_d.cnt = t_burst;
            bt_d.rd  = start_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bt_q <= '0;
        else        bt_q <= bt_d;
    end

    assign busy    = (bt_q.cnt != '0);
    assign rd_busy = bt_q.rd;

    // R7: the window never outlasts the configured burst length
    p_burst_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bt_q.cnt <= t_burst);
    // R7: read marker only lives inside a running window
    p_rd_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bt_q.rd |-> (bt_q.cnt != '0));
endmodule

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot
    import sbt_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_op_e      op,
    input  logic [CW-1:0] t_rcd,
    input  logic [CW-1:0] t_rp,
    input  logic [CW-1:0] t_rfc,
    input  logic [CW-1:0] t_mrd,
    input  logic [CW-1:0] t_burst,
    output bank_state_e   state
);
    localparam int TW = CW + 1;

    typedef struct packed {
        bank_state_e   st;
        logic [TW-1:0] cnt;
    } slot_t;

    slot_t sl_d, sl_q;
    logic  timed;

    assign timed = (sl_q.st != BK_IDLE) && (sl_q.st != BK_OPEN);

    always_comb begin
        sl_d = sl_q;
        if (timed) begin
            sl_d.cnt = sl_q.cnt - TW'(1);
            if (sl_q.cnt == TW'(1))
                sl_d.st = (sl_q.st == BK_OPENING) ? BK_OPEN : BK_IDLE;
        end
        case (op)
            OP_ACT:  begin sl_d.st = BK_OPENING; sl_d.cnt = {1'b0, t_rcd}; end
            OP_PRE:  begin sl_d.st = BK_CLOSING; sl_d.cnt = {1'b0, t_rp};  end
            OP_RDAP: begin sl_d.st = BK_RD_AUTO; sl_d.cnt = {1'b0, t_burst} + {1'b0, t_rp}; end
            OP_WRAP: begin sl_d.st = BK_WR_AUTO; sl_d.cnt = {1'b0, t_burst} + {1'b0, t_rp}; end
            OP_REF:  begin sl_d.st = BK_REFRESH; sl_d.cnt = {1'b0, t_rfc}; end
            OP_MRS:  begin sl_d.st = BK_MODE;    sl_d.cnt = {1'b0, t_mrd}; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sl_q <= '{st: BK_IDLE, cnt: '0};
        else        sl_q <= sl_d;
    end

    assign state = sl_q.st;

    // R8: a timed state always has cycles left to run
    p_timed_has_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timed |-> (sl_q.cnt != '0));
    // R1: opening is only ever requested of an idle bank
    p_open_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACT) |-> (sl_q.st == BK_IDLE));
    // R6: auto-closing access only ever starts from an open row
    p_auto_from_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RDAP || op == OP_WRAP) |-> (sl_q.st == BK_OPEN));
    // R4: a refresh request only reaches an idle bank
    p_refresh_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REF || op == OP_MRS) |-> (sl_q.st == BK_IDLE));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CW        = 6,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        bank_sel,
    input  logic                   a10,
    input  logic [CW-1:0]          cfg_trcd,
    input  logic [CW-1:0]          cfg_trp,
    input  logic [CW-1:0]          cfg_trfc,
    input  logic [CW-1:0]          cfg_tmrd,
    input  logic [CW-1:0]          cfg_burst,
    output logic [3*NUM_BANKS-1:0] bank_state,
    output logic                   all_idle,
    output logic                   violation
);
    typedef struct packed {
        logic [CW-1:0] trcd;
        logic [CW-1:0] trp;
        logic [CW-1:0] trfc;
        logic [CW-1:0] tmrd;
        logic [CW-1:0] burst;
        logic          viol;
    } top_t;

    top_t        tp_d, tp_q;
    cmd_kind_e   kind;
    bank_state_e st   [NUM_BANKS];
    bank_op_e    ops  [NUM_BANKS];
    logic        burst_busy, burst_rd_busy;
    logic        burst_go, burst_go_rd;
    logic        legal, every_idle, every_steady;
    bank_state_e tgt;

    function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
        return (v == '0) ? CW'(1) : v;
    endfunction

    sbt_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .kind (kind)
    );

    sbt_burst_timer #(.CW(CW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (burst_go),
        .start_rd (burst_go_rd),
        .t_burst  (tp_q.burst),
        .busy     (burst_busy),
        .rd_busy  (burst_rd_busy)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sbt_bank_slot #(.CW(CW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (ops[g]),
            .t_rcd   (tp_q.trcd),
            .t_rp    (tp_q.trp),
            .t_rfc   (tp_q.trfc),
            .t_mrd   (tp_q.tmrd),
            .t_burst (tp_q.burst),
            .state   (st[g])
        );
        assign bank_state[3*g +: 3] = st[g];
    end

    always_comb begin
        every_idle   = 1'b1;
        every_steady = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (st[i] != BK_IDLE) every_idle = 1'b0;
            if (st[i] != BK_IDLE && st[i] != BK_OPEN) every_steady = 1'b0;
        end
    end

    assign tgt = st[bank_sel];

    always_comb begin
        tp_d        = tp_q;
        burst_go    = 1'b0;
        burst_go_rd = 1'b0;
        legal       = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) ops[i] = OP_NONE;
        case (kind)
            K_NOP, K_DESEL: legal = 1'b1;
            K_ACT: begin
                legal = (tgt == BK_IDLE);
                ops[bank_sel] = OP_ACT;
            end
            K_RD: begin
                legal = (tgt == BK_OPEN);
                if (a10) ops[bank_sel] = OP_RDAP;
                burst_go    = 1'b1;
                burst_go_rd = 1'b1;
            end
            K_WR: begin
                legal = (tgt == BK_OPEN) && !burst_rd_busy;
                if (a10) ops[bank_sel] = OP_WRAP;
                burst_go = 1'b1;
            end
            K_PRE: begin
                if (a10) begin
                    legal = every_steady;
                    for (int i = 0; i < NUM_BANKS; i++) ops[i] = OP_PRE;
                end else begin
                    legal = (tgt == BK_IDLE) || (tgt == BK_OPEN);
                    ops[bank_sel] = OP_PRE;
                end
            end
            K_REF: begin
                legal = every_idle && !burst_busy;
                for (int i = 0; i < NUM_BANKS; i++) ops[i] = OP_REF;
            end
            K_MRS: begin
                legal = every_idle && !burst_busy;
                for (int i = 0; i < NUM_BANKS; i++) ops[i] = OP_MRS;
            end
            default: legal = 1'b0;
        endcase
        if (!legal) begin
            for (int i = 0; i < NUM_BANKS; i++) ops[i] = OP_NONE;
            burst_go    = 1'b0;
            burst_go_rd = 1'b0;
        end
        tp_d.viol = !legal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q.trcd  <= at_least_one(cfg_trcd);
            tp_q.trp   <= at_least_one(cfg_trp);
            tp_q.trfc  <= at_least_one(cfg_trfc);
            tp_q.tmrd  <= at_least_one(cfg_tmrd);
            tp_q.burst <= at_least_one(cfg_burst);
            tp_q.viol  <= 1'b0;
        end else begin
            tp_q <= tp_d;
        end
    end

    assign all_idle  = every_idle;
    assign violation = tp_q.viol;

    // R7: a write during a read window is always flagged
    p_wr_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_WR && burst_rd_busy) |=> violation);
    // R4: refresh with a busy bank is flagged
    p_refresh_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_REF && !all_idle) |=> violation);
    // R9: no-operation never produces a pulse
    p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NOP || kind == K_DESEL) |=> !violation);
    // R9: reserved code always produces a pulse
    p_reserved_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_RSV) |=> violation);
endmodule

// File: tb/sdram_bank_tracker_test.sv
module sdram_bank_tracker_test;
    localparam int NB = 4;
    localparam int CW = 6;

    localparam logic [3:0] C_NOP = 4'b0111, C_DES = 4'b1111, C_ACT = 4'b0011,
                           C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                           C_REF = 4'b0001, C_MRS = 4'b0000, C_RSV = 4'b0110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cmd = C_NOP;
    logic [1:0] ba = '0;
    logic a10 = 1'b0;
    logic [CW-1:0] trcd, trp, trfc, tmrd, tburst;
    logic [3*NB-1:0] bank_state;
    logic all_idle, violation;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sdram_bank_tracker #(.NUM_BANKS(NB), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cs_n(cmd[3]), .ras_n(cmd[2]), .cas_n(cmd[1]), .we_n(cmd[0]),
        .bank_sel(ba), .a10(a10),
        .cfg_trcd(trcd), .cfg_trp(trp), .cfg_trfc(trfc), .cfg_tmrd(tmrd),
        .cfg_burst(tburst),
        .bank_state(bank_state), .all_idle(all_idle), .violation(violation)
    );

    function automatic logic [11:0] s4(input int b3, input int b2, input int b1, input int b0);
        return {3'(b3), 3'(b2), 3'(b1), 3'(b0)};
    endfunction

    function automatic logic [24:0] rw(input int req, input logic [3:0] c, input int b,
                                       input logic ap, input logic v, input logic [11:0] s,
                                       input logic idl);
        return {4'(req), c, 2'(b), ap, v, s, idl};
    endfunction

    // trcd=2 trp=3 trfc=4 tmrd=2 burst=2, captured in reset
    localparam int NV = 47;
    localparam logic [24:0] VEC [NV] = '{
        rw(1,  C_ACT, 0, 0, 0, s4(0,0,0,1), 0),  // R1 open bank 0
        rw(1,  C_NOP, 0, 0, 0, s4(0,0,0,1), 0),
        rw(10, C_NOP, 0, 0, 0, s4(0,0,0,2), 0),  // R10 open after 2, not 9
        rw(7,  C_RD,  0, 0, 0, s4(0,0,0,2), 0),  // R7 plain read
        rw(7,  C_WR,  0, 0, 1, s4(0,0,0,2), 0),  // R7 write inside read window
        rw(7,  C_NOP, 0, 0, 0, s4(0,0,0,2), 0),
        rw(7,  C_WR,  0, 0, 0, s4(0,0,0,2), 0),  // R7 write after window
        rw(12, C_ACT, 0, 0, 1, s4(0,0,0,2), 0),  // R12 open an open bank
        rw(1,  C_ACT, 1, 0, 0, s4(0,0,1,2), 0),
        rw(8,  C_RD,  1, 0, 1, s4(0,0,1,2), 0),  // R8 read while opening
        rw(1,  C_NOP, 0, 0, 0, s4(0,0,2,2), 0),
        rw(2,  C_PRE, 0, 0, 0, s4(0,0,2,3), 0),  // R2 close bank 0
        rw(6,  C_RD,  1, 1, 0, s4(0,0,4,3), 0),  // R6 auto-closing read
        rw(2,  C_NOP, 0, 0, 0, s4(0,0,4,3), 0),
        rw(2,  C_NOP, 0, 0, 0, s4(0,0,4,0), 0),
        rw(4,  C_REF, 0, 0, 1, s4(0,0,4,0), 0),  // R4 refresh with busy bank
        rw(6,  C_NOP, 0, 0, 0, s4(0,0,4,0), 0),
        rw(11, C_NOP, 0, 0, 0, s4(0,0,0,0), 1),  // R11 all idle again
        rw(4,  C_REF, 0, 0, 0, s4(6,6,6,6), 0),  // R4 refresh
        rw(8,  C_MRS, 0, 0, 1, s4(6,6,6,6), 0),  // R8 mode load during refresh
        rw(4,  C_NOP, 0, 0, 0, s4(6,6,6,6), 0),
        rw(4,  C_NOP, 0, 0, 0, s4(6,6,6,6), 0),
        rw(4,  C_NOP, 0, 0, 0, s4(0,0,0,0), 1),
        rw(5,  C_MRS, 0, 0, 0, s4(7,7,7,7), 0),  // R5 mode load
        rw(5,  C_NOP, 0, 0, 0, s4(7,7,7,7), 0),
        rw(5,  C_NOP, 0, 0, 0, s4(0,0,0,0), 1),
        rw(9,  C_RSV, 0, 0, 1, s4(0,0,0,0), 1),  // R9 reserved code
        rw(9,  C_DES, 0, 0, 0, s4(0,0,0,0), 1),  // R9 deselect
        rw(1,  C_ACT, 2, 0, 0, s4(0,1,0,0), 0),
        rw(1,  C_NOP, 0, 0, 0, s4(0,1,0,0), 0),
        rw(1,  C_NOP, 0, 0, 0, s4(0,2,0,0), 0),
        rw(1,  C_ACT, 3, 0, 0, s4(1,2,0,0), 0),
        rw(8,  C_PRE, 0, 1, 1, s4(1,2,0,0), 0),  // R8 close-all while opening
        rw(1,  C_NOP, 0, 0, 0, s4(2,2,0,0), 0),
        rw(3,  C_PRE, 0, 1, 0, s4(3,3,3,3), 0),  // R3 close all
        rw(3,  C_NOP, 0, 0, 0, s4(3,3,3,3), 0),
        rw(3,  C_NOP, 0, 0, 0, s4(3,3,3,3), 0),
        rw(3,  C_NOP, 0, 0, 0, s4(0,0,0,0), 1),
        rw(1,  C_ACT, 2, 0, 0, s4(0,1,0,0), 0),
        rw(1,  C_NOP, 0, 0, 0, s4(0,1,0,0), 0),
        rw(1,  C_NOP, 0, 0, 0, s4(0,2,0,0), 0),
        rw(6,  C_WR,  2, 1, 0, s4(0,5,0,0), 0),  // R6 auto-closing write
        rw(6,  C_NOP, 0, 0, 0, s4(0,5,0,0), 0),
        rw(6,  C_NOP, 0, 0, 0, s4(0,5,0,0), 0),
        rw(6,  C_NOP, 0, 0, 0, s4(0,5,0,0), 0),
        rw(6,  C_NOP, 0, 0, 0, s4(0,5,0,0), 0),
        rw(6,  C_NOP, 0, 0, 0, s4(0,0,0,0), 1)
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input int b, input logic ap);
        @(negedge clk);
        cmd = c; ba = 2'(b); a10 = ap;
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset(input int rcd, input int rp, input int rfc, input int mrd, input int bl);
        @(negedge clk);
        rst_n = 1'b0; cmd = C_NOP;
        trcd = CW'(rcd); trp = CW'(rp); trfc = CW'(rfc); tmrd = CW'(mrd); tburst = CW'(bl);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        trcd = CW'(9); trp = CW'(9); trfc = CW'(9); tmrd = CW'(9); tburst = CW'(9);
        @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset(2, 3, 4, 2, 2);
        // R11 reset state
        check("R11 states", int'(bank_state), 0);
        check("R11 all_idle", int'(all_idle), 1);
        check("R11 violation", int'(violation), 0);

        for (int i = 0; i < NV; i++) begin
            logic [24:0] r;
            r = VEC[i];
            issue(r[20:17], int'(r[16:15]), r[14]);
            checks++;
            if (bank_state !== r[12:1] || violation !== r[13] || all_idle !== r[0]) begin
                fails++;
                $display("FAIL R%0d row %0d: state %h/%h viol %b/%b idle %b/%b",
                         r[24:21], i, bank_state, r[12:1], violation, r[13], all_idle, r[0]);
            end
        end

        // R10 zero treated as one; minimum timing
        do_reset(0, 1, 1, 1, 1);
        check("R11 states after second reset", int'(bank_state), 0);
        issue(C_ACT, 1, 0);
        check("R1 opening with tRCD of one", int'(bank_state), int'(s4(0,0,1,0)));
        issue(C_NOP, 0, 0);
        check("R10 open after one cycle", int'(bank_state), int'(s4(0,0,2,0)));
        issue(C_PRE, 1, 0);
        check("R2 closing", int'(bank_state), int'(s4(0,0,3,0)));
        issue(C_NOP, 0, 0);
        check("R2 idle after one cycle", int'(bank_state), 0);
        issue(C_PRE, 0, 0);
        check("R2 close of idle bank is legal", int'(violation), 0);
        check("R2 close of idle bank state", int'(bank_state), int'(s4(0,0,0,3)));
        issue(C_RD, 2, 0);
        check("R12 read to idle bank", int'(violation), 1);
        check("R9 ignored command keeps state", int'(bank_state), 0);
        issue(C_NOP, 0, 0);
        check("R9 pulse lasts one cycle", int'(violation), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule